// File: doc/BRIEF.md
# Core Module Control Register Bank

This block is the control and status register bank of a processor core module. It sits on a simple 32-bit register bus that is word addressed. It holds identification constants, a primary and an auxiliary clock-synthesizer setting, an SDRAM configuration word, an initialisation word and a small control word. It also holds two flag words, each written through separate set and clear slots. A one-source software interrupt has separate normal (IRQ) and fast (FIQ) enable masks. A read-only window shows the memory-module presence-detect bytes.

The two synthesizer settings are guarded by a 16-bit unlock key. Software loads the key into the key register, writes the settings, and then loads any other value to lock them again. The control word drives three board signals: the LED output, the select that chooses between boot flash and RAM at low memory, and a one-cycle board-reset request. Any access to an offset the bank does not define reads as zero, raises an error flag for that access and changes no state.

Top module: `cmr_ctrl_regs`

## Requirements
- R1: Word index 0 reads 0x411A3001, index 1 reads 0, and index 4 reads 0x00100000. After reset, index 2 reads 0x01000048, index 7 reads 0x0007FEFF, index 9 reads 0x00000112, index 3 reads 0, and index 5 reads 0.
- R2: After reset, the SDRAM word (index 8) reads 0x00011122 ORed with a size code taken from parameter MEM_MB. The code is 0x10 for MEM_MB of 256 or more, 0x0C for 128 or more, 0x08 for 64 or more, 0x04 for 32 or more, and 0 below 32.
- R3: A write to index 5 keeps only data bits [15:0]. Index 5 reads 0x0001A05F while the kept value is 0xA05F; otherwise it reads the kept value, zero-extended.
- R4: A write to index 2 or index 7 replaces that word only while the key register holds 0xA05F. At any other time the write is dropped, and the error flag stays low.
- R5: Index 12 reads the flag word, and a write to index 12 ORs the data into it. A write to index 13 clears the flag bits written as 1. Indices 14 and 15 do the same for a second flag word, which reads at index 14. Both flag words reset to 0.
- R6: Indices 8 and 9 are plain read/write words.
- R7: A write to index 3 stores data bits [2:0], which read back at index 3 with bits [31:3] as zero. Stored bit 0 drives `led_on`. Stored bit 2 drives `low_mem_ram`: 0 means boot flash is mapped at low memory (the reset state), and 1 means RAM is mapped there.
- R8: A write to index 3 with data bit 3 set raises `board_rst` for exactly one clock cycle, in the cycle after the write.
- R9: A one-bit software interrupt level is set by writing bit 0 = 1 to index 20 and cleared by writing bit 0 = 1 to index 21. Index 17 reads the level. Index 16 reads the level ANDed with the IRQ mask. Index 20 reads the level. Index 18 reads the 32-bit IRQ mask; a write to 18 ORs the data into the mask, and a write to 19 clears the mask bits written as 1.
- R10: Indices 24, 25, 26 and 27 behave like 16, 17, 18 and 19, but they use a separate FIQ mask.
- R11: `int_req` is high exactly when the level is 1 and bit 0 of the IRQ mask or of the FIQ mask is 1.
- R12: Word indices 64 to 95 (byte offsets 0x100 to 0x17F) read presence-detect byte number equal to the index, zero-extended. Bytes 73 to 83 hold the ASCII text "CORE-MODULE"; bytes 64 to 72 and 84 to 95 are zero. Indices 96 to 127 read 0. Writes into the window are undefined accesses.
- R13: Indices 32 to 35 read 0 and accept writes with no effect, with the error flag low.
- R14: Undefined accesses are these: reads of 6, 10, 11, 13, 15, 19, 21, 22, 23, 27 and 28 to 31, and reads of 36 and above outside the window; writes of 0, 1, 4, 6, 10, 11, 16, 17, 22 to 25 and 28 to 31, and writes of 36 and above. Such an access reads 0, drives `bus_err` high while `bus_en` is high, and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_en | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_word_addr | input | WADDR_W | Word index (byte offset bits above bit 1) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the access |
| bus_err | output | 1 | Undefined access this cycle |
| low_mem_ram | output | 1 | 1 = RAM at low memory, 0 = boot flash |
| led_on | output | 1 | LED drive |
| board_rst | output | 1 | One-cycle board reset request |
| int_req | output | 1 | Core-module interrupt request |

## Verification
The bench builds the bank with MEM_MB = 128, so the reset SDRAM word must carry size code 0x0C and not the default's 0x08. It keeps WADDR_W at 10, so random word indices reach up to 1023. That range covers the defined registers, both halves of the presence-detect window and the undefined space above it. Random unlock-key writes are mixed with random synthesizer writes, so writes land both while the key is loaded and while it is not.

// File: rtl/cmr_pkg.sv
package cmr_pkg;

    localparam int CMR_DW     = 32;
    localparam int CMR_KEY_W  = 16;
    localparam int CMR_CTRL_W = 3;
    localparam int CMR_IX_W   = 6;

    localparam logic [CMR_DW-1:0]    CMR_ID_WORD     = 32'h411A_3001;
    localparam logic [CMR_DW-1:0]    CMR_STATUS_WORD = 32'h0010_0000;
    localparam logic [CMR_KEY_W-1:0] CMR_UNLOCK_KEY  = 16'hA05F;
    localparam logic [CMR_DW-1:0]    CMR_OSC_RST     = 32'h0100_0048;
    localparam logic [CMR_DW-1:0]    CMR_AUX_RST     = 32'h0007_FEFF;
    localparam logic [CMR_DW-1:0]    CMR_INIT_RST    = 32'h0000_0112;
    localparam logic [CMR_DW-1:0]    CMR_SDRAM_BASE  = 32'h0001_1122;

    // Word indices; the layout is what software decodes.
    localparam logic [CMR_IX_W-1:0] IX_ID       = 6'd0;
    localparam logic [CMR_IX_W-1:0] IX_PROC     = 6'd1;
    localparam logic [CMR_IX_W-1:0] IX_OSC      = 6'd2;
    localparam logic [CMR_IX_W-1:0] IX_CTRL     = 6'd3;
    localparam logic [CMR_IX_W-1:0] IX_STAT     = 6'd4;
    localparam logic [CMR_IX_W-1:0] IX_LOCK     = 6'd5;
    localparam logic [CMR_IX_W-1:0] IX_AUX      = 6'd7;
    localparam logic [CMR_IX_W-1:0] IX_SDRAM    = 6'd8;
    localparam logic [CMR_IX_W-1:0] IX_INIT     = 6'd9;
    localparam logic [CMR_IX_W-1:0] IX_FLG_SET  = 6'd12;
    localparam logic [CMR_IX_W-1:0] IX_FLG_CLR  = 6'd13;
    localparam logic [CMR_IX_W-1:0] IX_NVF_SET  = 6'd14;
    localparam logic [CMR_IX_W-1:0] IX_NVF_CLR  = 6'd15;
    localparam logic [CMR_IX_W-1:0] IX_IRQ_STAT = 6'd16;
    localparam logic [CMR_IX_W-1:0] IX_IRQ_RAW  = 6'd17;
    localparam logic [CMR_IX_W-1:0] IX_IRQ_ENS  = 6'd18;
    localparam logic [CMR_IX_W-1:0] IX_IRQ_ENC  = 6'd19;
    localparam logic [CMR_IX_W-1:0] IX_SWI_SET  = 6'd20;
    localparam logic [CMR_IX_W-1:0] IX_SWI_CLR  = 6'd21;
    localparam logic [CMR_IX_W-1:0] IX_FIQ_STAT = 6'd24;
    localparam logic [CMR_IX_W-1:0] IX_FIQ_RAW  = 6'd25;
    localparam logic [CMR_IX_W-1:0] IX_FIQ_ENS  = 6'd26;
    localparam logic [CMR_IX_W-1:0] IX_FIQ_ENC  = 6'd27;
    localparam logic [CMR_IX_W-1:0] IX_VOLT_LO  = 6'd32;
    localparam logic [CMR_IX_W-1:0] IX_VOLT_HI  = 6'd35;

    // Presence-detect text and where it starts in the byte table.
    localparam int               CMR_PD_TXT_LEN = 11;
    localparam int               CMR_PD_TXT_AT  = 73;
    localparam logic [8*CMR_PD_TXT_LEN-1:0] CMR_PD_TXT = "CORE-MODULE";

    typedef struct packed {
        logic [CMR_KEY_W-1:0] key;
        logic [CMR_DW-1:0]    osc;
        logic [CMR_DW-1:0]    aux;
    } osc_state_t;

    typedef struct packed {
        logic              lvl;
        logic [CMR_DW-1:0] irq_en;
        logic [CMR_DW-1:0] fiq_en;
    } int_state_t;

    typedef struct packed {
        logic [CMR_DW-1:0]     sdram;
        logic [CMR_DW-1:0]     init;
        logic [CMR_CTRL_W-1:0] ctrl;
        logic                  rst_pulse;
    } top_state_t;

    function automatic logic [CMR_DW-1:0] cmr_sdram_rst(input int mem_mb);
        logic [CMR_DW-1:0] code;
        if (mem_mb >= 256)      code = 32'h10;
        else if (mem_mb >= 128) code = 32'h0C;
        else if (mem_mb >= 64)  code = 32'h08;
        else if (mem_mb >= 32)  code = 32'h04;
        else                    code = 32'h00;
        return CMR_SDRAM_BASE | code;
    endfunction

    function automatic logic [7:0] cmr_pd_byte(input logic [6:0] idx);
        int k;
        logic [7:0] b;
        b = 8'h00;
        k = int'(idx) - CMR_PD_TXT_AT;
        if (k >= 0 && k < CMR_PD_TXT_LEN)
            b = CMR_PD_TXT[8*(CMR_PD_TXT_LEN-1-k) +: 8];
        return b;
    endfunction

endpackage

// File: rtl/cmr_keyed_osc.sv
module cmr_keyed_osc
    import cmr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 key_we,
    input  logic                 osc_we,
    input  logic                 aux_we,
    input  logic [CMR_DW-1:0]    wdata,
    output logic [CMR_KEY_W-1:0] key_val,
    output logic                 key_ok,
    output logic [CMR_DW-1:0]    osc_val,
    output logic [CMR_DW-1:0]    aux_val
);

    localparam osc_state_t OSC_RST = '{key: '0, osc: CMR_OSC_RST, aux: CMR_AUX_RST};

    osc_state_t st_d, st_q;

    assign key_ok  = (st_q.key == CMR_UNLOCK_KEY);
    assign key_val = st_q.key;
    assign osc_val = st_q.osc;
    assign aux_val = st_q.aux;

    always_comb begin
        st_d = st_q;
        if (key_we)
            st_d.key = wdata[CMR_KEY_W-1:0];
        if (osc_we && key_ok)
            st_d.osc = wdata;
        if (aux_we && key_ok)
            st_d.aux = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= OSC_RST;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/cmr_setclr_reg.sv
module cmr_setclr_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] value
);

    logic [W-1:0] val_d, val_q;

    assign value = val_q;

    always_comb begin
        val_d = val_q;
        if (set_we) val_d = val_q | wdata;
        if (clr_we) val_d = val_q & ~wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) val_q <= '0;
        else        val_q <= val_d;
    end

endmodule

// File: rtl/cmr_soft_int.sv
module cmr_soft_int
    import cmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              swi_set,
    input  logic              swi_clr,
    input  logic              irq_en_set,
    input  logic              irq_en_clr,
    input  logic              fiq_en_set,
    input  logic              fiq_en_clr,
    input  logic [CMR_DW-1:0] wdata,
    output logic              lvl,
    output logic [CMR_DW-1:0] irq_en,
    output logic [CMR_DW-1:0] fiq_en,
    output logic              int_req
);

    int_state_t st_d, st_q;

    assign lvl    = st_q.lvl;
    assign irq_en = st_q.irq_en;
    assign fiq_en = st_q.fiq_en;
    // Only source 0 exists, so only mask bit 0 can route it.
    assign int_req = st_q.lvl & (st_q.irq_en[0] | st_q.fiq_en[0]);

    always_comb begin
        st_d = st_q;
        if (swi_set && wdata[0]) st_d.lvl = 1'b1;
        if (swi_clr && wdata[0]) st_d.lvl = 1'b0;
        if (irq_en_set) st_d.irq_en = st_q.irq_en | wdata;
        if (irq_en_clr) st_d.irq_en = st_q.irq_en & ~wdata;
        if (fiq_en_set) st_d.fiq_en = st_q.fiq_en | wdata;
        if (fiq_en_clr) st_d.fiq_en = st_q.fiq_en & ~wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/cmr_ctrl_regs.sv
module cmr_ctrl_regs
    import cmr_pkg::*;
#(
    parameter int WADDR_W = 10,
    parameter int MEM_MB  = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_en,
    input  logic               bus_we,
    input  logic [WADDR_W-1:0] bus_word_addr,
    input  logic [CMR_DW-1:0]  bus_wdata,
    output logic [CMR_DW-1:0]  bus_rdata,
    output logic               bus_err,
    output logic               low_mem_ram,
    output logic               led_on,
    output logic               board_rst,
    output logic               int_req
);

    localparam int SEG_W          = WADDR_W - CMR_IX_W;
    localparam int N_FLAG         = 2;
    localparam int CTRL_LED_BIT   = 0;
    localparam int CTRL_REMAP_BIT = 2;
    localparam int CTRL_RST_BIT   = 3;

    localparam top_state_t TOP_RST = '{
        sdram:     cmr_sdram_rst(MEM_MB),
        init:      CMR_INIT_RST,
        ctrl:      '0,
        rst_pulse: 1'b0
    };

    // ---------------- address decode ----------------
    logic [CMR_IX_W-1:0] ix;
    logic [SEG_W-1:0]    seg;
    logic                in_regs, in_win;
    logic                wr_ok, rd_ok, wr_go;

    assign ix      = bus_word_addr[CMR_IX_W-1:0];
    assign seg     = bus_word_addr[WADDR_W-1:CMR_IX_W];
    assign in_regs = (seg == '0);
    assign in_win  = (seg == SEG_W'(1));

    always_comb begin
        wr_ok = 1'b0;
        if (in_regs) begin
            wr_ok = ix inside {IX_OSC, IX_CTRL, IX_LOCK, IX_AUX, IX_SDRAM, IX_INIT,
                               [IX_FLG_SET:IX_NVF_CLR], [IX_IRQ_ENS:IX_SWI_CLR],
                               IX_FIQ_ENS, IX_FIQ_ENC, [IX_VOLT_LO:IX_VOLT_HI]};
        end
    end

    assign wr_go = bus_en & bus_we & wr_ok;

    logic we_osc, we_ctrl, we_key, we_aux, we_sdram, we_init;
    logic we_swi_s, we_swi_c, we_irq_s, we_irq_c, we_fiq_s, we_fiq_c;

    assign we_osc   = wr_go && (ix == IX_OSC);
    assign we_ctrl  = wr_go && (ix == IX_CTRL);
    assign we_key   = wr_go && (ix == IX_LOCK);
    assign we_aux   = wr_go && (ix == IX_AUX);
    assign we_sdram = wr_go && (ix == IX_SDRAM);
    assign we_init  = wr_go && (ix == IX_INIT);
    assign we_irq_s = wr_go && (ix == IX_IRQ_ENS);
    assign we_irq_c = wr_go && (ix == IX_IRQ_ENC);
    assign we_swi_s = wr_go && (ix == IX_SWI_SET);
    assign we_swi_c = wr_go && (ix == IX_SWI_CLR);
    assign we_fiq_s = wr_go && (ix == IX_FIQ_ENS);
    assign we_fiq_c = wr_go && (ix == IX_FIQ_ENC);

    // ---------------- keyed synthesizer settings ----------------
    logic [CMR_KEY_W-1:0] key_val;
    logic                 key_ok;
    logic [CMR_DW-1:0]    osc_val, aux_val;

    cmr_keyed_osc u_osc (
        .clk     (clk),
        .rst_n   (rst_n),
        .key_we  (we_key),
        .osc_we  (we_osc),
        .aux_we  (we_aux),
        .wdata   (bus_wdata),
        .key_val (key_val),
        .key_ok  (key_ok),
        .osc_val (osc_val),
        .aux_val (aux_val)
    );

    // ---------------- flag words, set/clear pairs ----------------
    logic [N_FLAG-1:0][CMR_DW-1:0] flag_val;

    for (genvar g = 0; g < N_FLAG; g++) begin : g_flag
        localparam logic [CMR_IX_W-1:0] SET_IX = IX_FLG_SET + CMR_IX_W'(2 * g);
        localparam logic [CMR_IX_W-1:0] CLR_IX = SET_IX + CMR_IX_W'(1);
        cmr_setclr_reg #(.W(CMR_DW)) u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_we (wr_go && (ix == SET_IX)),
            .clr_we (wr_go && (ix == CLR_IX)),
            .wdata  (bus_wdata),
            .value  (flag_val[g])
        );
    end

    // ---------------- software interrupt ----------------
    logic              int_lvl;
    logic [CMR_DW-1:0] irq_en, fiq_en;

    cmr_soft_int u_int (
        .clk        (clk),
        .rst_n      (rst_n),
        .swi_set    (we_swi_s),
        .swi_clr    (we_swi_c),
        .irq_en_set (we_irq_s),
        .irq_en_clr (we_irq_c),
        .fiq_en_set (we_fiq_s),
        .fiq_en_clr (we_fiq_c),
        .wdata      (bus_wdata),
        .lvl        (int_lvl),
        .irq_en     (irq_en),
        .fiq_en     (fiq_en),
        .int_req    (int_req)
    );

    // ---------------- local words and control ----------------
    top_state_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.rst_pulse = 1'b0;
        if (we_sdram) st_d.sdram = bus_wdata;
        if (we_init)  st_d.init  = bus_wdata;
        if (we_ctrl) begin
            st_d.ctrl      = bus_wdata[CMR_CTRL_W-1:0];
            st_d.rst_pulse = bus_wdata[CTRL_RST_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= TOP_RST;
        else        st_q <= st_d;
    end

    assign led_on      = st_q.ctrl[CTRL_LED_BIT];
    assign low_mem_ram = st_q.ctrl[CTRL_REMAP_BIT];
    assign board_rst   = st_q.rst_pulse;

    // ---------------- read mux ----------------
    logic [CMR_DW-1:0] rdat;

    always_comb begin
        rd_ok = 1'b1;
        rdat  = '0;
        if (in_win) begin
            rdat = {24'h0, cmr_pd_byte({1'b1, ix})};
        end else if (!in_regs) begin
            rd_ok = 1'b0;
        end else begin
            case (ix)
                IX_ID:       rdat = CMR_ID_WORD;
                IX_PROC:     rdat = '0;
                IX_OSC:      rdat = osc_val;
                IX_CTRL:     rdat = {{(CMR_DW-CMR_CTRL_W){1'b0}}, st_q.ctrl};
                IX_STAT:     rdat = CMR_STATUS_WORD;
                IX_LOCK:     rdat = key_ok ? {15'h0, 1'b1, key_val}
                                           : {{(CMR_DW-CMR_KEY_W){1'b0}}, key_val};
                IX_AUX:      rdat = aux_val;
                IX_SDRAM:    rdat = st_q.sdram;
                IX_INIT:     rdat = st_q.init;
                IX_FLG_SET:  rdat = flag_val[0];
                IX_NVF_SET:  rdat = flag_val[1];
                IX_IRQ_STAT: rdat = {31'h0, int_lvl & irq_en[0]};
                IX_IRQ_RAW:  rdat = {31'h0, int_lvl};
                IX_IRQ_ENS:  rdat = irq_en;
                IX_SWI_SET:  rdat = {31'h0, int_lvl};
                IX_FIQ_STAT: rdat = {31'h0, int_lvl & fiq_en[0]};
                IX_FIQ_RAW:  rdat = {31'h0, int_lvl};
                IX_FIQ_ENS:  rdat = fiq_en;
                6'd32, 6'd33, 6'd34, 6'd35: rdat = '0;
                default:     rd_ok = 1'b0;
            endcase
        end
    end

    assign bus_rdata = (bus_en && !bus_we) ? rdat : '0;
    assign bus_err   = bus_en && (bus_we ? !wr_ok : !rd_ok);

endmodule

// File: rtl/cmr_regs_chk.sv
module cmr_regs_chk
    import cmr_pkg::*;
#(
    parameter int WADDR_W = 10
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_en,
    input logic               bus_we,
    input logic [WADDR_W-1:0] bus_word_addr,
    input logic [CMR_DW-1:0]  bus_rdata,
    input logic               bus_err,
    input logic               low_mem_ram,
    input logic               led_on,
    input logic               board_rst,
    input logic               key_ok,
    input logic [CMR_DW-1:0]  osc_val,
    input logic [CMR_DW-1:0]  aux_val
);

    logic rd_now, ctrl_wr;
    assign rd_now  = bus_en && !bus_we;
    assign ctrl_wr = bus_en && bus_we && (bus_word_addr == WADDR_W'(3));

    a_r1_id_const: assert property (@(posedge clk) disable iff (!rst_n)
        rd_now && bus_word_addr == WADDR_W'(0) |-> bus_rdata == 32'h411A_3001);

    a_r3_key_readback: assert property (@(posedge clk) disable iff (!rst_n)
        rd_now && bus_word_addr == WADDR_W'(5) |-> bus_rdata[16] == key_ok);

    a_r4_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !key_ok |=> $stable(osc_val) && $stable(aux_val));

    a_r7_ctrl_only: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr |=> $stable(low_mem_ram) && $stable(led_on));

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        board_rst |=> !board_rst);

    a_r12_upper_window_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_now && bus_word_addr >= WADDR_W'(96) && bus_word_addr < WADDR_W'(128)
        |-> bus_rdata == '0 && !bus_err);

    a_r13_volt_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_now && bus_word_addr >= WADDR_W'(32) && bus_word_addr <= WADDR_W'(35)
        |-> bus_rdata == '0 && !bus_err);

    a_r14_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        bus_en && bus_err |=> $stable(low_mem_ram) && $stable(led_on)
                              && $stable(osc_val) && !board_rst);

endmodule

bind cmr_ctrl_regs cmr_regs_chk #(.WADDR_W(WADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_en        (bus_en),
    .bus_we        (bus_we),
    .bus_word_addr (bus_word_addr),
    .bus_rdata     (bus_rdata),
    .bus_err       (bus_err),
    .low_mem_ram   (low_mem_ram),
    .led_on        (led_on),
    .board_rst     (board_rst),
    .key_ok        (key_ok),
    .osc_val       (osc_val),
    .aux_val       (aux_val)
);

// File: tb/cmr_ctrl_regs_bench.sv
module cmr_ctrl_regs_bench;

    localparam int WA = 10;
    localparam int MB = 128;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_en = 1'b0;
    logic          bus_we = 1'b0;
    logic [WA-1:0] bus_word_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          bus_err, low_mem_ram, led_on, board_rst, int_req;

    always #5 clk = ~clk;

    cmr_ctrl_regs #(.WADDR_W(WA), .MEM_MB(MB)) u_cmr_ctrl_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_en        (bus_en),
        .bus_we        (bus_we),
        .bus_word_addr (bus_word_addr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .bus_err       (bus_err),
        .low_mem_ram   (low_mem_ram),
        .led_on        (led_on),
        .board_rst     (board_rst),
        .int_req       (int_req)
    );

    int    n_chk = 0;
    int    n_bad = 0;
    bit    done = 0;
    string pd_txt = "CORE-MODULE";

    // reference model
    logic [31:0] m_osc, m_aux, m_sdram, m_init, m_flg, m_nvf, m_irqen, m_fiqen;
    logic [15:0] m_key;
    logic [2:0]  m_ctrl;
    logic        m_lvl;

    int idx_pool [30] = '{0, 1, 2, 3, 4, 5, 7, 8, 9, 12, 13, 14, 15, 16, 17, 18, 19,
                          20, 21, 24, 25, 26, 27, 32, 35, 64, 73, 80, 95, 100};

    task automatic model_reset();
        m_osc = 32'h0100_0048; m_aux = 32'h0007_FEFF; m_init = 32'h0000_0112;
        m_sdram = 32'h0001_112E;   // size code 0x0C for 128 MB (R2)
        m_flg = '0; m_nvf = '0; m_irqen = '0; m_fiqen = '0;
        m_key = '0; m_ctrl = '0; m_lvl = 1'b0;
    endtask

    function automatic bit key_in();
        return m_key == 16'hA05F;
    endfunction

    function automatic logic model_int();
        return m_lvl & (m_irqen[0] | m_fiqen[0]);
    endfunction

    function automatic logic [32:0] model_read(input int idx);
        logic [31:0] d;
        bit ok;
        d = '0; ok = 1'b1;
        case (idx)
            0: d = 32'h411A_3001;
            1: d = '0;
            2: d = m_osc;
            3: d = {29'h0, m_ctrl};
            4: d = 32'h0010_0000;
            5: d = key_in() ? 32'h0001_A05F : {16'h0, m_key};
            7: d = m_aux;
            8: d = m_sdram;
            9: d = m_init;
            12: d = m_flg;
            14: d = m_nvf;
            16: d = {31'h0, m_lvl & m_irqen[0]};
            17, 20, 25: d = {31'h0, m_lvl};
            18: d = m_irqen;
            24: d = {31'h0, m_lvl & m_fiqen[0]};
            26: d = m_fiqen;
            32, 33, 34, 35: d = '0;
            default: begin
                if (idx >= 64 && idx < 128) begin
                    if (idx >= 73 && idx <= 83) d = {24'h0, pd_txt[idx-73]};
                end else begin
                    ok = 1'b0;
                end
            end
        endcase
        return {ok, d};
    endfunction

    function automatic bit write_ok(input int idx);
        case (idx)
            2, 3, 5, 7, 8, 9, 12, 13, 14, 15, 18, 19, 20, 21, 26, 27,
            32, 33, 34, 35: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic model_write(input int idx, input logic [31:0] d);
        case (idx)
            2: if (key_in()) m_osc = d;
            7: if (key_in()) m_aux = d;
            3: m_ctrl = d[2:0];
            5: m_key = d[15:0];
            8: m_sdram = d;
            9: m_init = d;
            12: m_flg = m_flg | d;
            13: m_flg = m_flg & ~d;
            14: m_nvf = m_nvf | d;
            15: m_nvf = m_nvf & ~d;
            18: m_irqen = m_irqen | d;
            19: m_irqen = m_irqen & ~d;
            20: if (d[0]) m_lvl = 1'b1;
            21: if (d[0]) m_lvl = 1'b0;
            26: m_fiqen = m_fiqen | d;
            27: m_fiqen = m_fiqen & ~d;
            default: ;
        endcase
    endtask

    function automatic string tag_of(input int idx);
        if (idx == 0 || idx == 1 || idx == 4) return "R1";
        if (idx == 2 || idx == 7) return "R4";
        if (idx == 3) return "R7";
        if (idx == 5) return "R3";
        if (idx == 8 || idx == 9) return "R6";
        if (idx >= 12 && idx <= 15) return "R5";
        if (idx >= 16 && idx <= 21) return "R9";
        if (idx >= 24 && idx <= 27) return "R10";
        if (idx >= 32 && idx <= 35) return "R13";
        if (idx >= 64 && idx <= 127) return "R12";
        return "R14";
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one access: drive at a falling edge, sample 1 ns later, commit at the
    // next rising edge, check board outputs at the following falling edge
    task automatic access(input bit we, input int idx, input logic [31:0] wd);
        logic [32:0] exp;
        bit          pulse_exp;
        @(negedge clk);
        exp = model_read(idx);
        bus_en = 1'b1; bus_we = we; bus_word_addr = WA'(idx); bus_wdata = wd;
        #1;
        if (we) begin
            check({tag_of(idx), "/R14 write err"}, 32'(bus_err), 32'(!write_ok(idx)));
        end else begin
            check({tag_of(idx), " read"}, bus_rdata, exp[31:0]);
            check({tag_of(idx), "/R14 read err"}, 32'(bus_err), 32'(!exp[32]));
        end
        pulse_exp = we && idx == 3 && wd[3];
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
        if (we) model_write(idx, wd);
        #1;
        check("R7 led", 32'(led_on), 32'(m_ctrl[0]));
        check("R7 remap", 32'(low_mem_ram), 32'(m_ctrl[2]));
        check("R8 reset pulse", 32'(board_rst), 32'(pulse_exp));
        check("R11 int_req", 32'(int_req), 32'(model_int()));
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R14: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int idx;
        int r;
        bit we;
        logic [31:0] d;

        void'($urandom(32'h5EED_0042));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 reset led", 32'(led_on), 32'h0);
        check("R7 reset remap flash", 32'(low_mem_ram), 32'h0);
        check("R8 reset no pulse", 32'(board_rst), 32'h0);
        check("R11 reset int", 32'(int_req), 32'h0);

        // R1 R2 constants and reset values
        access(0, 0, '0); access(0, 1, '0); access(0, 4, '0);
        access(0, 2, '0); access(0, 7, '0); access(0, 9, '0);
        access(0, 3, '0); access(0, 5, '0);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_word_addr = WA'(8);
        #1;
        check("R2 sdram size code", bus_rdata, 32'h0001_112E);
        @(negedge clk);
        bus_en = 1'b0;

        // R4 dropped while locked, R3 key behaviour
        access(1, 2, 32'hDEAD_BEEF); access(0, 2, '0);
        access(1, 5, 32'h1234_A05F); access(0, 5, '0);
        access(1, 2, 32'h1111_2222); access(1, 7, 32'h3333_4444);
        access(0, 2, '0); access(0, 7, '0);
        access(1, 5, 32'hFFFF_A05E); access(0, 5, '0);
        access(1, 7, 32'h0BAD_0BAD); access(0, 7, '0);

        // R5 flags
        access(1, 12, 32'h0000_00F0); access(1, 13, 32'h0000_0030); access(0, 12, '0);
        access(1, 14, 32'h8000_0001); access(1, 15, 32'h0000_0001); access(0, 14, '0);

        // R6 R7 R8
        access(1, 8, 32'hA5A5_5A5A); access(0, 8, '0);
        access(1, 9, 32'h0000_0000); access(0, 9, '0);
        access(1, 3, 32'h0000_0005); access(0, 3, '0);
        access(1, 3, 32'hFFFF_FFFA); access(0, 3, '0);
        @(negedge clk);
        #1;
        check("R8 pulse one cycle", 32'(board_rst), 32'h0);

        // R9 R10 R11
        access(1, 20, 32'h1); access(0, 17, '0); access(0, 16, '0);
        access(1, 18, 32'h8000_0001); access(0, 16, '0); access(0, 18, '0);
        access(1, 19, 32'h1); access(1, 26, 32'h1); access(0, 24, '0);
        access(1, 21, 32'h0); access(0, 25, '0);
        access(1, 21, 32'h1); access(0, 20, '0);
        access(1, 27, 32'hFFFF_FFFF); access(0, 26, '0);

        // R12 window, R13 voltage, R14 undefined
        access(0, 64, '0); access(0, 73, '0); access(0, 78, '0); access(0, 83, '0);
        access(0, 95, '0); access(0, 96, '0); access(0, 127, '0);
        access(1, 33, 32'hFFFF_FFFF); access(0, 33, '0);
        access(0, 6, '0); access(0, 13, '0); access(0, 128, '0); access(0, 1023, '0);
        access(1, 0, 32'hFFFF_FFFF); access(1, 4, 32'h1); access(1, 16, 32'h1);
        access(1, 70, 32'h1); access(1, 200, 32'hFFFF_FFFF);
        access(0, 12, '0); access(0, 3, '0);

        // constrained random
        for (int i = 0; i < 4000; i++) begin
            r  = int'($urandom_range(99));
            we = 1'($urandom_range(1));
            d  = $urandom();
            if (r < 12) begin
                we  = 1'b1;
                idx = 5;
                if ($urandom_range(1) == 1) d = (d & 32'hFFFF_0000) | 32'h0000_A05F;
            end else if (r < 78) begin
                idx = idx_pool[$urandom_range(29)];
            end else begin
                idx = int'($urandom_range(1023));
            end
            access(we, idx, d);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule